// File: doc/BRIEF.md
# Dual-Mode Byte Queue with Status Word

This block is a synchronous first-in first-out queue of bytes for one direction of a serial port. On the receive side the line engine pushes each byte it collects and software drains the queue. On the transmit side software fills the queue and the line engine pops from it. A single parameter picks the side. That choice changes what the two low bits of the status word mean, so each side can use those bits directly as interrupt requests.

The depth is a power of two. It is chosen by a requested base-2 logarithm that the block clamps into a safe range. Popped bytes come out of a register, one clock after the pop strobe. A 16-bit status word carries the size of the queue, how many entries are in use, and the two interrupt bits. A one-cycle error pulse reports a pop from an empty queue or a push into a full one. An asynchronous active-low reset empties the queue.

Top module: `dual_mode_fifo`

## Requirements
- R1: The effective base-2 depth is the requested value clamped to the range 2 to 10. It is reported in status bits [15:12], and the queue holds 2 to the power of that value bytes.
- R2: Bytes leave in the order they were accepted. A pop accepted at a clock edge presents the oldest byte on `pop_data` right after that edge, and `pop_data` holds until the next accepted pop.
- R3: `not_empty` is high exactly when at least one byte is stored.
- R4: Status bits [11:2] hold the number of stored bytes, saturating at 1023. This number never exceeds the depth.
- R5: Status bit 0 depends on the mode. In receive mode it is high when the queue is not empty. In transmit mode it is high when at least one slot is free.
- R6: Status bit 1 depends on the mode. In receive mode it is high when the fill exceeds half the depth. In transmit mode it is high when the fill is below half the depth.
- R7: A pop while empty leaves the fill and `pop_data` unchanged, and `err` is high for the cycle after that edge.
- R8: A push while full with no pop in the same cycle is dropped. The fill stays at the depth and `err` is high for the cycle after that edge.
- R9: A push and a pop in the same cycle on a non-empty queue, including a full one, are both accepted and leave the fill unchanged.
- R10: While `rst_n` is low the queue is empty, the fill is zero and `err` is low. No byte stored before the reset can be popped after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| push | input | 1 | Push strobe |
| push_data | input | 8 | Byte to push |
| pop | input | 1 | Pop strobe |
| pop_data | output | 8 | Registered popped byte |
| not_empty | output | 1 | At least one byte stored |
| status | output | 16 | {log2 depth, fill count, bit 1, bit 0} |
| err | output | 1 | One-cycle pulse after a pop on empty or a dropped push |

## Verification
The bench builds three copies of the block. The main copy requests a log2 depth of 2 in receive mode, so four pushes reach the full state, the overflow case and a simultaneous push and pop on a full queue. A transmit-mode copy requests 1, which is clamped up to 2. It is driven with the same strobes, so the inverted meaning of both interrupt bits is checked at every fill level. A third copy requests 12, which exercises the clamp at the upper end through the size field.

// File: rtl/dmf_pkg.sv
package dmf_pkg;
  localparam int LG_MIN    = 2;
  localparam int LG_MAX    = 10;
  localparam int STAT_W    = 16;
  localparam int FILL_LSB  = 2;
  localparam int FILL_W    = 10;
  localparam int DATA_W    = 8;

  function automatic int clamp_lg(input int req);
    if (req < LG_MIN) return LG_MIN;
    if (req > LG_MAX) return LG_MAX;
    return req;
  endfunction
endpackage

// File: rtl/dmf_ctrl.sv
module dmf_ctrl #(
  parameter int LG    = 4,
  localparam int DEPTH = 1 << LG
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  output logic          wr_en,
  output logic          rd_en,
  output logic [LG-1:0] wr_ptr,
  output logic [LG-1:0] rd_ptr,
  output logic [LG:0]   fill,
  output logic          err
);
  logic [LG-1:0] wr_ptr_nx, rd_ptr_nx;
  logic [LG:0]   fill_nx;
  logic          err_nx, empty, full;

  always_comb begin
    empty     = (fill == '0);
    full      = (fill == (LG+1)'(DEPTH));
    rd_en     = pop && !empty;
    wr_en     = push && (!full || rd_en);
    err_nx    = (pop && empty) || (push && full && !rd_en);
    wr_ptr_nx = wr_en ? wr_ptr + 1'b1 : wr_ptr;
    rd_ptr_nx = rd_en ? rd_ptr + 1'b1 : rd_ptr;
    fill_nx   = fill;
    if (wr_en && !rd_en) fill_nx = fill + 1'b1;
    if (rd_en && !wr_en) fill_nx = fill - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
      err    <= 1'b0;
    end else begin
      wr_ptr <= wr_ptr_nx;
      rd_ptr <= rd_ptr_nx;
      fill   <= fill_nx;
      err    <= err_nx;
    end
  end
endmodule

// File: rtl/dmf_store.sv
module dmf_store #(
  parameter int LG     = 4,
  parameter int DATA_W = 8,
  localparam int DEPTH = 1 << LG
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [LG-1:0]     wr_ptr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [LG-1:0]     rd_ptr,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rd_data_nx;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_data;
  end

  always_comb rd_data_nx = rd_en ? mem[rd_ptr] : rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data <= '0;
    else        rd_data <= rd_data_nx;
  end
endmodule

// File: rtl/dmf_status.sv
module dmf_status #(
  parameter int LG      = 4,
  parameter bit RX_MODE = 1'b1,
  localparam int DEPTH  = 1 << LG
) (
  input  logic [LG:0]  fill,
  output logic [15:0]  status
);
  import dmf_pkg::*;
  logic [10:0]       fill_ext;
  logic [FILL_W-1:0] fill_sat;
  logic              irq0, irq1;

  always_comb begin
    fill_ext = 11'(fill);
    fill_sat = (fill_ext > 11'd1023) ? '1 : fill_ext[FILL_W-1:0];
  end

  generate
    if (RX_MODE) begin : g_rx
      always_comb begin
        irq0 = (fill != '0);
        irq1 = (fill > (LG+1)'(DEPTH/2));
      end
    end else begin : g_tx
      always_comb begin
        irq0 = (fill != (LG+1)'(DEPTH));
        irq1 = (fill < (LG+1)'(DEPTH/2));
      end
    end
  endgenerate

  always_comb status = {4'(LG), fill_sat, irq1, irq0};
endmodule

// File: rtl/dual_mode_fifo.sv
module dual_mode_fifo #(
  parameter int LG_REQ  = 4,
  parameter bit RX_MODE = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        push,
  input  logic [7:0]  push_data,
  input  logic        pop,
  output logic [7:0]  pop_data,
  output logic        not_empty,
  output logic [15:0] status,
  output logic        err
);
  localparam int LG    = dmf_pkg::clamp_lg(LG_REQ);
  localparam int DEPTH = 1 << LG;

  logic          wr_en, rd_en;
  logic [LG-1:0] wr_ptr, rd_ptr;
  logic [LG:0]   fill;

  dmf_ctrl #(.LG(LG)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
    .wr_en(wr_en), .rd_en(rd_en), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
    .fill(fill), .err(err)
  );

  dmf_store #(.LG(LG), .DATA_W(dmf_pkg::DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ptr(wr_ptr),
    .wr_data(push_data), .rd_en(rd_en), .rd_ptr(rd_ptr), .rd_data(pop_data)
  );

  dmf_status #(.LG(LG), .RX_MODE(RX_MODE)) u_stat (
    .fill(fill), .status(status)
  );

  always_comb not_empty = (fill != '0);
endmodule

// File: rtl/dmf_chk.sv
module dmf_chk #(
  parameter int LG      = 4,
  parameter bit RX_MODE = 1'b1,
  localparam int DEPTH  = 1 << LG
) (
  input logic        clk,
  input logic        rst_n,
  input logic        push,
  input logic        pop,
  input logic        not_empty,
  input logic [15:0] status,
  input logic        err,
  input logic [LG:0] fill
);
  // R4: the occupancy never passes the capacity
  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= (LG+1)'(DEPTH));

  // R7: a pop on an empty queue is flagged on the next cycle
  p_pop_empty_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !not_empty) |=> err);

  // R8: a push into a full queue without a pop is dropped and flagged
  p_drop_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && fill == (LG+1)'(DEPTH)) |=> (err && fill == (LG+1)'(DEPTH)));

  // R9: a simultaneous push and pop on a non-empty queue keeps the fill
  p_hold_fill_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop && not_empty) |=> $stable(fill));

  // R5: interrupt bit 0 against the flag and fill driven elsewhere
  p_bit0_mode_r5: assert property (@(posedge clk) disable iff (!rst_n)
    RX_MODE ? (status[0] == not_empty) : (status[0] == (fill != (LG+1)'(DEPTH))));

  // R10: the queue is empty while reset is held
  always @(posedge clk) begin
    if (!rst_n) p_reset_empty_r10: assert (!not_empty && !err);
  end
endmodule

bind dual_mode_fifo dmf_chk #(.LG(LG), .RX_MODE(RX_MODE)) u_chk (
  .clk(clk), .rst_n(rst_n), .push(push), .pop(pop), .not_empty(not_empty),
  .status(status), .err(err), .fill(fill)
);

// File: tb/tb_dual_mode_fifo.sv
`timescale 1ns/1ps
module tb_dual_mode_fifo;
  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        push = 1'b0, pop = 1'b0;
  logic [7:0]  push_data = '0;
  logic [7:0]  pop_data, pop_data_tx, pop_data_w;
  logic        not_empty, not_empty_tx, not_empty_w;
  logic [15:0] status, status_tx, status_w;
  logic        err, err_tx, err_w;

  int n_checks = 0, n_fail = 0;
  int mcount = 0;
  logic [7:0] exp_q[$];
  logic [7:0] want;
  logic [7:0] last_pop = '0;
  logic       exp_err = 1'b0;
  event       mon_ev;

  always #5 clk = ~clk;

  dual_mode_fifo #(.LG_REQ(2), .RX_MODE(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .push(push), .push_data(push_data), .pop(pop),
    .pop_data(pop_data), .not_empty(not_empty), .status(status), .err(err));

  dual_mode_fifo #(.LG_REQ(1), .RX_MODE(1'b0)) dut_tx (
    .clk(clk), .rst_n(rst_n), .push(push), .push_data(push_data), .pop(pop),
    .pop_data(pop_data_tx), .not_empty(not_empty_tx), .status(status_tx), .err(err_tx));

  dual_mode_fifo #(.LG_REQ(12), .RX_MODE(1'b1)) dut_wide (
    .clk(clk), .rst_n(rst_n), .push(push), .push_data(push_data), .pop(pop),
    .pop_data(pop_data_w), .not_empty(not_empty_w), .status(status_w), .err(err_w));

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, expv, $time);
    end
  endtask

  // monitor: compares each popped byte with the scoreboard head
  always @(mon_ev) begin
    check(pop_data == want, "R2 order", pop_data, want);
  end

  task automatic check_state();
    check(not_empty == (mcount > 0), "R3 not_empty", not_empty, mcount > 0);
    check(int'(status[11:2]) == mcount, "R4 fill field", status[11:2], mcount);
    check(status[0] == (mcount > 0), "R5 rx bit0", status[0], mcount > 0);
    check(status_tx[0] == (mcount < DEPTH), "R5 tx bit0", status_tx[0], mcount < DEPTH);
    check(status[1] == (mcount > DEPTH/2), "R6 rx bit1", status[1], mcount > DEPTH/2);
    check(status_tx[1] == (mcount < DEPTH/2), "R6 tx bit1", status_tx[1], mcount < DEPTH/2);
    check(err == exp_err, "R7/R8 err", err, exp_err);
    check(err_tx == exp_err, "R7/R8 tx err", err_tx, exp_err);
  endtask

  // driver: one clock of strobes, scoreboard updated from the requirements
  task automatic step(input bit p, input logic [7:0] d, input bit q);
    bit pop_ok, push_ok;
    @(negedge clk);
    push = p; push_data = d; pop = q;
    pop_ok  = q && (mcount > 0);
    push_ok = p && (mcount < DEPTH || pop_ok);
    exp_err = (q && mcount == 0) || (p && mcount == DEPTH && !pop_ok);
    @(posedge clk);
    #1;
    push = 1'b0; pop = 1'b0;
    if (pop_ok) begin
      want = exp_q.pop_front();
      last_pop = want;
      mcount--;
      ->mon_ev;
    end
    if (push_ok) begin
      exp_q.push_back(d);
      mcount++;
    end
    #1;
    if (!pop_ok) check(pop_data == last_pop, "R7 pop_data held", pop_data, last_pop);
    check_state();
  endtask

  initial begin
    #200000;
    n_fail++;
    n_checks++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check(!not_empty && status[11:2] == 0 && !err, "R10 reset", status, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: clamp of the size field
    check(status[15:12] == 4'd2, "R1 lg rx", status[15:12], 2);
    check(status_tx[15:12] == 4'd2, "R1 lg low clamp", status_tx[15:12], 2);
    check(status_w[15:12] == 4'd10, "R1 lg high clamp", status_w[15:12], 10);
    check_state();

    step(0, 8'h00, 1);                 // R7 pop on empty
    step(0, 8'h00, 0);                 // err pulse ends
    step(1, 8'hA1, 0);
    step(1, 8'hB2, 0);
    step(1, 8'hC3, 0);                 // R6 rx above half
    step(1, 8'hD4, 0);                 // full
    step(1, 8'hEE, 0);                 // R8 dropped
    step(1, 8'h55, 1);                 // R9 push and pop on full
    step(0, 8'h00, 1);
    step(0, 8'h00, 1);
    step(0, 8'h00, 1);
    step(0, 8'h00, 1);                 // R2 last byte 55
    step(0, 8'h00, 1);                 // R7 empty again
    step(1, 8'h11, 0);
    step(1, 8'h22, 1);                 // R9 non-full overlap
    step(1, 8'h33, 0);
    step(0, 8'h00, 1);
    step(1, 8'h44, 0);
    step(1, 8'h66, 0);

    // R10: reset discards stored bytes
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    exp_q.delete();
    mcount = 0;
    exp_err = 1'b0;
    last_pop = 8'h00;
    check(!not_empty && status[11:2] == 0, "R10 reset empties", status[11:2], 0);
    check(pop_data == 8'h00, "R10 pop_data cleared", pop_data, 0);
    @(negedge clk);
    rst_n = 1'b1;
    step(0, 8'h00, 1);                 // R10 nothing left to pop
    step(1, 8'h77, 0);
    step(0, 8'h00, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule